// File: doc/BRIEF.md
# Square-root carry-select adder

This block adds two 32-bit unsigned operands and a carry-in, giving a 32-bit sum and a carry-out, with no clock and no storage. The operand word is cut into bit groups that widen toward the most significant end. The lowest group is a plain ripple adder. Every higher group computes its slice twice, once assuming the incoming carry is 0 and once assuming it is 1. The real carry arriving from the group below then picks one of the two results.

Because each group is wider than the one beneath it, its two candidate sums take longer to settle. The select carry also arrives later, since it has passed through more stages. Sizing the groups so that these two delays roughly match keeps the critical path close to the square root of the word width, not linear in it.

The block is dropped into a datapath as a combinational cell. Any register or handshake around it belongs to the surrounding pipeline. The group plan is derived from two parameters: the word width, and the width of the lowest group. Each group is one bit wider than the group below it, and the top group takes whatever bits remain.

Top module: `csel_sqrt_adder`

## Requirements
- R1: For every input, {cout_o, sum_o} equals the 33-bit unsigned value a_i + b_i + cin_i.
- R2: With the default parameters the groups are, from the LSB upward, bits [3:0], [8:4], [14:9], [21:15], [29:22] and [31:30]. The group at bits [3:0] is a single ripple adder whose carry-in is cin_i.
- R3: Each group above the lowest outputs its operand slice sum plus the carry leaving the group directly below it. A carry produced at the top bit of any group appears as a 1 at the lowest bit of the next group's sum field.
- R4: cout_o is the carry leaving the group at bits [31:30]. A carry created only in bit 31 sets cout_o, and a sum with no carry out of bit 31 leaves cout_o at 0.
- R5: a_i = all ones with b_i = 0 and cin_i = 1 gives sum_o = 0 and cout_o = 1. All ones plus all ones plus 1 gives all ones with cout_o = 1.
- R6: All-zero operands with cin_i = 0 give sum_o = 0 and cout_o = 0. With cin_i = 1 they give sum_o = 1 and cout_o = 0.
- R7: A carry entering at bit 0, through cin_i or through b_i = 1, propagates through an all-ones run that ends at any group boundary. It lands as the single set bit just above that run.
- R8: The block has no clock or reset. sum_o and cout_o follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First unsigned operand |
| b_i | input | 32 | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Low 32 bits of the total |
| cout_o | output | 1 | Carry out of bit 31 |

## Verification
The hardest situation to reach from the ports is a select carry that crosses a group boundary while the upper group's two precomputed candidates differ in every bit. In that case the wrong multiplexer choice would be glaring, yet random operands almost never produce a full-width carry run that stops exactly at a boundary. The bench builds such operands directly. For each boundary it uses an all-ones mask reaching up to that boundary, plus a single 1 either in b_i or on cin_i, so that the carry crosses every lower group before it lands. Random vectors then cover ordinary mixed carry patterns.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Number of groups: widths start at first_w and grow by one until the word is covered.
  function automatic int unsigned grp_count(input int unsigned width, input int unsigned first_w);
    int unsigned acc;
    int unsigned n;
    acc = 0;
    n   = 0;
    while (acc < width) begin
      acc = acc + first_w + n;
      n   = n + 1;
    end
    return n;
  endfunction

  // Lowest bit index of group idx.
  function automatic int unsigned grp_lo(input int unsigned idx, input int unsigned first_w);
    return idx * first_w + (idx * (idx - ((idx == 0) ? 0 : 1))) / 2;
  endfunction

  // Width of group idx; the top group is clipped to the remaining bits.
  function automatic int unsigned grp_w(input int unsigned idx, input int unsigned width,
                                        input int unsigned first_w);
    int unsigned lo;
    int unsigned nominal;
    lo      = grp_lo(idx, first_w);
    nominal = first_w + idx;
    return (lo + nominal > width) ? (width - lo) : nominal;
  endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] s_o,
  output logic         cout_o
);

  logic [W:0] chain;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic half;
    assign half        = a_i[i] ^ b_i[i];
    assign s_o[i]      = half ^ chain[i];
    assign chain[i+1]  = (a_i[i] & b_i[i]) | (half & chain[i]);
  end

  assign cout_o = chain[W];

  always_comb begin
    AST_RIPPLE_ARITH: assert ({cout_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i)))
      else $error("ripple slice result differs from arithmetic sum"); // R1
  end

endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int W = 5
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W-1:0] sum_zero;
  logic [W-1:0] sum_one;
  logic         cy_zero;
  logic         cy_one;

  csel_ripple #(.W(W)) u_assume0 (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (1'b0),
    .s_o   (sum_zero),
    .cout_o(cy_zero)
  );

  csel_ripple #(.W(W)) u_assume1 (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (1'b1),
    .s_o   (sum_one),
    .cout_o(cy_one)
  );

  always_comb begin
    sum_o  = sel_i ? sum_one : sum_zero;
    cout_o = sel_i ? cy_one  : cy_zero;
  end

  always_comb begin
    AST_PAIR_STEP: assert ({cy_one, sum_one} == ({cy_zero, sum_zero} + (W+1)'(1)))
      else $error("candidate pair not one apart"); // R3
    AST_GROUP_ARITH: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(sel_i)))
      else $error("selected group result wrong for incoming carry"); // R3
  end

endmodule

// File: rtl/csel_sqrt_adder.sv
module csel_sqrt_adder #(
  parameter int WIDTH   = 32,
  parameter int FIRST_W = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  import csel_pkg::*;

  localparam int NGRP = int'(grp_count(WIDTH, FIRST_W));

  logic [NGRP:0] grp_carry;

  assign grp_carry[0] = cin_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = int'(grp_lo(g, FIRST_W));
    localparam int GW = int'(grp_w(g, WIDTH, FIRST_W));
    if (g == 0) begin : g_base
      csel_ripple #(.W(GW)) u_base (
        .a_i   (a_i[LO +: GW]),
        .b_i   (b_i[LO +: GW]),
        .cin_i (grp_carry[g]),
        .s_o   (sum_o[LO +: GW]),
        .cout_o(grp_carry[g+1])
      );
    end else begin : g_sel
      csel_group #(.W(GW)) u_sel (
        .a_i   (a_i[LO +: GW]),
        .b_i   (b_i[LO +: GW]),
        .sel_i (grp_carry[g]),
        .sum_o (sum_o[LO +: GW]),
        .cout_o(grp_carry[g+1])
      );
    end
  end

  assign cout_o = grp_carry[NGRP];

  localparam int BASE_W = FIRST_W;

  always_comb begin
    AST_WORD_TOTAL: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i)))
      else $error("word sum mismatch"); // R1
    AST_BASE_FROM_CIN: assert (sum_o[BASE_W-1:0] ==
                               (a_i[BASE_W-1:0] + b_i[BASE_W-1:0] + BASE_W'(cin_i)))
      else $error("lowest group not fed by carry-in"); // R2
  end

endmodule

// File: tb/csel_sqrt_adder_tb_top.sv
module csel_sqrt_adder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] a, b, sum;
  logic         cin, cout;

  logic [W:0] exp_q[$];
  string      tag_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  csel_sqrt_adder dut_i (
    .a_i   (a),
    .b_i   (b),
    .cin_i (cin),
    .sum_o (sum),
    .cout_o(cout)
  );

  // Driver: apply on the falling edge, push the expected 33-bit result.
  task automatic send(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci,
                      input string tag);
    @(negedge clk);
    a   = x;
    b   = y;
    cin = ci;
    exp_q.push_back({1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci});
    tag_q.push_back(tag);
  endtask

  // Monitor: at the rising edge, half a period after the inputs changed.
  always @(posedge clk) begin
    logic [W:0] e;
    string      t;
    if (!rst && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({cout, sum} !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, {cout, sum}, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R8 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] mask;
    int bnd[5];
    bnd = '{4, 9, 15, 22, 30};
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    send('0, '0, 1'b0, "R6 zero operands");
    send('0, '0, 1'b1, "R6 carry-in only");
    send('1, '0, 1'b1, "R5 all ones plus carry-in");
    send('1, '1, 1'b1, "R5 all ones twice plus carry-in");
    send(32'h0000_000F, 32'h0000_0001, 1'b0, "R2 lowest group carry out");
    send(32'h0000_0007, 32'h0000_0000, 1'b1, "R2 carry-in into lowest group");
    send(32'h0000_01F0, 32'h0000_0010, 1'b0, "R2 second group overflow");

    foreach (bnd[k]) begin
      mask = {W{1'b1}} >> (W - bnd[k]);
      send(mask, 32'h0000_0001, 1'b0, "R7 b=1 ripple to boundary");
      send(mask, 32'h0000_0000, 1'b1, "R7 cin ripple to boundary");
      send(mask, ~mask, 1'b1, "R3 select flips full upper field");
      send(mask, mask, 1'b0, "R3 doubled run across boundary");
    end

    send(32'h8000_0000, 32'h8000_0000, 1'b0, "R4 carry from bit 31 only");
    send(32'hC000_0000, 32'h4000_0000, 1'b0, "R4 top group carry");
    send('1, '0, 1'b0, "R4 no carry out");
    send(32'h3FFF_FFFF, 32'h0000_0001, 1'b0, "R4 carry into top group only");

    for (int i = 0; i < 400; i++) begin
      send($urandom, $urandom, 1'($urandom), "R1 random operands");
    end
    for (int i = 0; i < 4; i++) begin
      send($urandom, 32'h0, 1'b0, "R8 settles without clock");
    end

    while (exp_q.size() != 0) @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule